// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing core of a PWM channel pair. It divides a base clock through two prescalers in series and uses the resulting tick to step a 16-bit counter. The counter can count up, count down, count up and then down, or hold. Compare and waveform logic elsewhere takes the live count and two single-cycle event strobes. One strobe fires when the count becomes zero, the other when it becomes the period value.

Software sets up the block through a small 16-bit register port. The registers are a control word, a period register and a read-only view of the counter. The period can be adopted at the next zero crossing, so that an update does not tear the current cycle. It can also be adopted on the very next tick. While the counter is held, a new period takes effect at once, so a fresh start always uses the value just written.

Top module: `pwm_timebase`

## Requirements
- R1: After reset, the following hold. The counter reads 0 and both strobes are low. The control word reads 0x0003, which is the hold mode. The period register reads the reset value 0xFFFF.
- R2: The counter steps once every A*B base-clock cycles. A is 2^p, where p is control bits 12:10. B is 2*h, where h is control bits 9:7, and B is 1 when h is 0. The first step from a hold comes A*B cycles after the control write.
- R3: With control bits 1:0 = 0 (up), each step adds one. From a value at or above the active period P, the next step goes to 0, so the sequence repeats every P+1 steps.
- R4: With control bits 1:0 = 1 (down), each step subtracts one. From 0, the next step loads P.
- R5: With control bits 1:0 = 2 (up-down), the count rises from 0 to P and then falls back to 0, so the sequence repeats every 2P steps. With P = 0 it stays at 0.
- R6: With control bits 1:0 = 3 (hold), the counter does not change and neither strobe fires.
- R7: Each time the counter steps to 0, zero_evt is high for exactly the first base cycle in which cnt_o shows 0. Each time it steps to the active period, prd_evt is high in the same way.
- R8: With control bit 3 = 0 (deferred load), a period write does not take effect at once. The written value becomes the active period at the step that takes the counter to 0.
- R9: With control bit 3 = 1 (immediate load), the written value becomes the active period at the first step after the write. It governs every step after that one.
- R10: A period write made while the counter is held becomes the active period at once.
- R11: Reads are combinational on addr. Address 0 returns the control word, with only bits 12:7, bit 3 and bits 1:0 kept and the other bits 0. Address 1 returns the last period value written. Address 2 returns the live count.
- R12: A write to address 2 changes neither the counter nor what is read back from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr |
| cnt_o | output | 16 | Live counter value |
| zero_evt | output | 1 | One-cycle strobe when the counter steps to 0 |
| prd_evt | output | 1 | One-cycle strobe when the counter steps to the period |

## Verification
A wrong prescaler state changes when cnt_o steps, so the error shows on cnt_o within one divide interval. A wrong direction bit or a wrong active period changes the value of the very next step, or the position of the next wrap. Either one shows on cnt_o within one counter period. Each state error also shifts or suppresses zero_evt and prd_evt in the same cycle. Every sample of cnt_o and of both strobes is therefore compared against a count computed arithmetically from elapsed cycles.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 2;
    localparam int SEL_W   = 3;
    localparam int PW_LSB  = 10;
    localparam int HS_LSB  = 7;
    localparam int IMM_BIT = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PRD = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT = 2'd2;

    typedef enum logic [1:0] {
        MODE_UP   = 2'd0,
        MODE_DOWN = 2'd1,
        MODE_UPDN = 2'd2,
        MODE_HOLD = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] pw_sel;
        logic [SEL_W-1:0] hs_sel;
        logic             imm_load;
        cnt_mode_e        mode;
    } ctl_t;

    function automatic ctl_t ctl_unpack(input logic [REG_W-1:0] w);
        ctl_t c;
        c.pw_sel   = w[PW_LSB +: SEL_W];
        c.hs_sel   = w[HS_LSB +: SEL_W];
        c.imm_load = w[IMM_BIT];
        c.mode     = cnt_mode_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctl_pack(input ctl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[PW_LSB +: SEL_W] = c.pw_sel;
        w[HS_LSB +: SEL_W] = c.hs_sel;
        w[IMM_BIT]         = c.imm_load;
        w[1:0]             = c.mode;
        return w;
    endfunction
endpackage

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale
    import pwm_tb_pkg::*;
#(
    parameter int SEL_WIDTH = SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [SEL_WIDTH-1:0] pw_sel,
    input  logic [SEL_WIDTH-1:0] hs_sel,
    output logic                 tick
);
    localparam int SEL_MAX = (1 << SEL_WIDTH) - 1;
    localparam int DIV_MAX = (1 << SEL_MAX) * 2 * SEL_MAX;
    localparam int DIV_W   = $clog2(DIV_MAX + 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } ps_state_t;

    ps_state_t        ps_d, ps_q;
    logic [DIV_W-1:0] hs_fac;
    logic [DIV_W-1:0] div_lim;

    always_comb begin
        hs_fac  = (hs_sel == '0) ? DIV_W'(1) : DIV_W'({hs_sel, 1'b0});
        div_lim = (hs_fac << pw_sel) - DIV_W'(1);
        ps_d    = ps_q;
        tick    = 1'b0;
        if (!run) begin
            ps_d.cnt = '0;
        end else if (ps_q.cnt >= div_lim) begin
            tick     = 1'b1;
            ps_d.cnt = '0;
        end else begin
            ps_d.cnt = ps_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int               CNT_W   = REG_W,
    parameter logic [CNT_W-1:0] PRD_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic             imm_load,
    input  logic             prd_wr,
    input  logic [CNT_W-1:0] prd_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] prd_act,
    output logic [CNT_W-1:0] prd_shd,
    output logic             zero_evt,
    output logic             prd_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir_down;
        logic [CNT_W-1:0] prd_act;
        logic [CNT_W-1:0] prd_shd;
        logic             zev;
        logic             pev;
    } ctr_state_t;

    ctr_state_t       st_d, st_q;
    logic [CNT_W-1:0] nxt;
    logic             nxt_down;

    always_comb begin
        nxt      = st_q.cnt;
        nxt_down = 1'b0;
        case (mode)
            MODE_UP: begin
                nxt = (st_q.cnt >= st_q.prd_act) ? '0 : st_q.cnt + CNT_W'(1);
            end
            MODE_DOWN: begin
                nxt = (st_q.cnt == '0) ? st_q.prd_act : st_q.cnt - CNT_W'(1);
            end
            MODE_UPDN: begin
                if (st_q.prd_act == '0) begin
                    nxt = '0;
                end else if (!st_q.dir_down) begin
                    if (st_q.cnt >= st_q.prd_act) begin
                        nxt      = st_q.cnt - CNT_W'(1);
                        nxt_down = 1'b1;
                    end else begin
                        nxt = st_q.cnt + CNT_W'(1);
                    end
                end else if (st_q.cnt == '0) begin
                    nxt = CNT_W'(1);
                end else begin
                    nxt      = st_q.cnt - CNT_W'(1);
                    nxt_down = 1'b1;
                end
            end
            default: begin
                nxt      = st_q.cnt;
                nxt_down = st_q.dir_down;
            end
        endcase

        st_d     = st_q;
        st_d.zev = 1'b0;
        st_d.pev = 1'b0;
        if (prd_wr) st_d.prd_shd = prd_wdata;
        if (mode == MODE_HOLD) begin
            if (prd_wr) st_d.prd_act = prd_wdata;
        end else if (tick) begin
            st_d.cnt      = nxt;
            st_d.dir_down = nxt_down;
            if (imm_load || nxt == '0) st_d.prd_act = st_q.prd_shd;
            st_d.zev = (nxt == '0);
            st_d.pev = (nxt == st_q.prd_act);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.prd_act <= PRD_RST;
            st_q.prd_shd <= PRD_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign prd_act  = st_q.prd_act;
    assign prd_shd  = st_q.prd_shd;
    assign zero_evt = st_q.zev;
    assign prd_evt  = st_q.pev;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter logic [REG_W-1:0] CTL_RST = 16'h0003,
    parameter logic [REG_W-1:0] PRD_RST = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic [REG_W-1:0]  cnt_o,
    output logic              zero_evt,
    output logic              prd_evt
);
    typedef struct packed {
        ctl_t ctl;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic             tick_w;
    logic             prd_wr_w;
    logic [1:0]       mode_w;
    logic [REG_W-1:0] prd_act_w;
    logic [REG_W-1:0] prd_shd_w;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == ADDR_CTL) st_d.ctl = ctl_unpack(wr_data);
        prd_wr_w = wr_en && (addr == ADDR_PRD);
        case (addr)
            ADDR_CTL: rd_data = ctl_pack(st_q.ctl);
            ADDR_PRD: rd_data = prd_shd_w;
            ADDR_CNT: rd_data = cnt_o;
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.ctl <= ctl_unpack(CTL_RST);
        else        st_q     <= st_d;
    end

    assign mode_w = st_q.ctl.mode;

    pwm_tb_prescale #(.SEL_WIDTH(SEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.ctl.mode != MODE_HOLD),
        .pw_sel (st_q.ctl.pw_sel),
        .hs_sel (st_q.ctl.hs_sel),
        .tick   (tick_w)
    );

    pwm_tb_counter #(.CNT_W(REG_W), .PRD_RST(PRD_RST)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .mode      (st_q.ctl.mode),
        .imm_load  (st_q.ctl.imm_load),
        .prd_wr    (prd_wr_w),
        .prd_wdata (wr_data),
        .cnt       (cnt_o),
        .prd_act   (prd_act_w),
        .prd_shd   (prd_shd_w),
        .zero_evt  (zero_evt),
        .prd_evt   (prd_evt)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cnt_o,
    input logic        zero_evt,
    input logic        prd_evt,
    input logic [1:0]  mode,
    input logic [15:0] prd_act
);
    // R7: the zero strobe only accompanies a zero count
    assert_zero_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |-> (cnt_o == 16'd0));

    // R7: the period strobe accompanies the period that was active for the step
    assert_prd_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prd_evt |-> (cnt_o == $past(prd_act)));

    // R6: a held counter keeps its value
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd3) |-> $stable(cnt_o));

    // R6: a held counter raises no strobe
    assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd3) |-> (!zero_evt && !prd_evt));

    // R3: up counting moves by one or wraps to zero
    assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd0 && cnt_o != $past(cnt_o))
            |-> (cnt_o == 16'($past(cnt_o) + 16'd1) || cnt_o == 16'd0));

    // R4: down counting moves by one or reloads from zero
    assert_down_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd1 && cnt_o != $past(cnt_o))
            |-> (cnt_o == 16'($past(cnt_o) - 16'd1) || $past(cnt_o) == 16'd0));
endmodule

bind pwm_timebase pwm_timebase_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_o    (cnt_o),
    .zero_evt (zero_evt),
    .prd_evt  (prd_evt),
    .mode     (mode_w),
    .prd_act  (prd_act_w)
);

// File: tb/pwm_timebase_test.sv
`timescale 1ns/1ps
module pwm_timebase_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic [15:0] cnt_o;
    logic        zero_evt;
    logic        prd_evt;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_timebase uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .cnt_o    (cnt_o),
        .zero_evt (zero_evt),
        .prd_evt  (prd_evt)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        addr = a;
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output int v);
        addr = a;
        #1;
        v = int'(rd_data);
    endtask

    function automatic int exp_cnt(input int mode, input int p, input int n);
        int m;
        case (mode)
            0: exp_cnt = n % (p + 1);
            1: exp_cnt = (p + 1 - (n % (p + 1))) % (p + 1);
            default: begin
                if (p == 0) exp_cnt = 0;
                else begin
                    m = n % (2 * p);
                    exp_cnt = (m <= p) ? m : 2 * p - m;
                end
            end
        endcase
    endfunction

    task automatic run_cfg(input int mode, input int pw, input int hs, input int p, input int k_max);
        int d;
        int e;
        bit t;
        string tag;
        d = ((hs == 0) ? 1 : 2 * hs) << pw;
        tag = (mode == 0) ? "R2 R3 up" : (mode == 1) ? "R2 R4 down" : "R2 R5 updown";
        do_reset();
        reg_wr(2'd1, 16'(p));
        reg_wr(2'd0, 16'((pw << 10) | (hs << 7) | mode));
        check("R2 start value", int'(cnt_o), 0);
        for (int k = 1; k <= k_max; k++) begin
            @(negedge clk);
            e = exp_cnt(mode, p, k / d);
            t = (k % d) == 0;
            check(tag, int'(cnt_o), e);
            check("R7 zero strobe", int'(zero_evt), int'(t && e == 0));
            check("R7 period strobe", int'(prd_evt), int'(t && e == p));
        end
    endtask

    task automatic load_seq(input bit imm, input int len, input int seq[10]);
        int v;
        do_reset();
        reg_wr(2'd1, 16'd5);
        reg_wr(2'd0, imm ? 16'h0008 : 16'h0000);
        reg_wr(2'd1, 16'd2);
        reg_rd(2'd1, v);
        check("R11 period readback", v, 2);
        for (int i = 0; i < len; i++) begin
            if (i > 0) @(negedge clk);
            check(imm ? "R9 immediate load" : "R8 deferred load", int'(cnt_o), seq[i]);
            reg_rd(2'd2, v);
            check("R11 counter readback", v, int'(cnt_o));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        int seq_i[10];
        int seq_s[10];
        seq_i = '{1, 2, 0, 1, 2, 0, 0, 0, 0, 0};
        seq_s = '{1, 2, 3, 4, 5, 0, 1, 2, 0, 1};

        do_reset();
        @(negedge clk);
        check("R1 count", int'(cnt_o), 0);
        check("R1 zero strobe", int'(zero_evt), 0);
        check("R1 period strobe", int'(prd_evt), 0);
        reg_rd(2'd0, v);
        check("R1 control", v, 16'h0003);
        reg_rd(2'd1, v);
        check("R1 period", v, 16'hFFFF);

        // R10: period written while held is used from the first step
        reg_wr(2'd1, 16'd3);
        reg_wr(2'd0, 16'h0000);
        repeat (4) @(negedge clk);
        check("R10 held period load", int'(cnt_o), 0);

        for (int mode = 0; mode < 3; mode++)
            for (int pw = 0; pw < 3; pw++)
                for (int hs = 0; hs < 3; hs++)
                    for (int pi = 0; pi < 4; pi++) begin
                        int p;
                        int d;
                        p = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 3 : 6;
                        d = ((hs == 0) ? 1 : 2 * hs) << pw;
                        run_cfg(mode, pw, hs, p, d * (2 * p + 3) + 2);
                    end

        // R2: largest divide ratio
        run_cfg(0, 7, 7, 1, 1792 * 2 + 3);

        // R6: hold keeps the value
        run_cfg(0, 0, 0, 6, 10);
        reg_wr(2'd0, 16'h0003);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check("R6 hold value", int'(cnt_o), 4);
            check("R6 hold strobes", int'(zero_evt | prd_evt), 0);
        end

        // R12: counter address is not writable
        reg_wr(2'd2, 16'h00AA);
        check("R12 count after write", int'(cnt_o), 4);
        reg_rd(2'd2, v);
        check("R12 counter readback", v, 4);

        // R11: control readback keeps only the defined fields
        reg_wr(2'd0, 16'hFFFF);
        reg_rd(2'd0, v);
        check("R11 control readback", v, 16'h1F8B);
        reg_wr(2'd1, 16'h1234);
        reg_rd(2'd1, v);
        check("R11 period readback", v, 16'h1234);

        load_seq(1'b1, 6, seq_i);
        load_seq(1'b0, 10, seq_s);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule